// File: doc/BRIEF.md
# Group-Zero System Register Bank

This block holds the system-control special-purpose registers of a 32-bit RISC core. A 16-bit register address is split into a 5-bit group field (bits 15:11) and an 11-bit register number (bits 10:0). Only group 0 is served here. Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high.

The identification words are build-time constants: the legacy version word, the CPU configuration word, the second version word and the architecture version word. Three registers are optional and are kept or dropped by parameter:
- the exception vector base,
- the arithmetic exception control/status pair,
- a bank of eight implementation-specific words.

The presence bits in the configuration word follow those parameters. The status register collects sticky flags raised by the ALU. Software clears them one bit at a time by writing zeros. The vector base, control and status values also leave the block on dedicated outputs for the exception logic.

Top module: `sysreg_grp0`

## Requirements
- R1: The address splits into group `spr_addr_i[15:11]` and number `spr_addr_i[10:0]`. Registers answer only when the group is 0, at these numbers: 0 legacy version, 2 configuration, 9 second version, 10 architecture version, 11 vector base, 12 arithmetic control, 13 arithmetic status, 21..28 implementation words.
- R2: Number 0 reads `VER_BASE` with bit 6 forced to 1.
- R3: Number 2 reads `CFG_BASE` with bits 10..14 replaced by presence bits:
  - bit 10: the no-delay-slot parameter;
  - bit 11: 1, because the architecture version word is always present;
  - bit 12: vector base present;
  - bit 13: implementation words present;
  - bit 14: arithmetic control/status present.
- R4: Number 9 reads `{CPU_ID[7:0], IMPL_VER[23:0]}`. Number 10 reads `ARCH_VER`.
- R5: Writes to numbers 0, 2, 9, 10 and 21..28 are ignored, and those registers read back unchanged.
- R6: The vector base (number 11) resets to 0. A write stores data bits 31:13. Bits 12:0 always read 0, so the base is 8 KB aligned.
- R7: The arithmetic control register (number 12) resets to 0. Its low `AE_W` bits are writable and its upper bits read 0.
- R8: The arithmetic status register (number 13) resets to 0. A 1 on `aes_set_i` sets the matching bit from the next cycle on, and that bit stays set until software clears it.
- R9: A write to the status register gives `(old & wdata) | aes_set_i`. Writing 0 clears a bit, writing 1 never sets one, and a hardware set in the same cycle wins.
- R10: Number 21+k (k = 0..7) reads word k of `ISR_INIT`, which is bits 32k+31:32k.
- R11: Every address with no register behind it reads 0, and a write to it changes no register. This includes any nonzero group.
- R12: When an optional register is disabled by parameter, its numbers read 0, ignore writes, and its presence bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_addr_i | input | 16 | Register address: group in bits 15:11, number in bits 10:0 |
| spr_we_i | input | 1 | Write strobe |
| spr_wdata_i | input | 32 | Write data |
| aes_set_i | input | AE_W | Set pulses from the ALU for the arithmetic status register |
| spr_rdata_o | output | 32 | Combinational read data |
| evbar_o | output | 32 | Current exception vector base |
| aecr_o | output | AE_W | Current arithmetic exception control bits |
| aesr_o | output | AE_W | Current arithmetic exception status bits |

## Verification
Two instances run side by side: one with every optional register enabled and one with all of them removed.

**Identification words and presence bits.** These are read from both instances. This separates the presence bits from the constant base word.

**Vector base.** It is written with all ones and then with a mixed pattern. This shows whether truncation happens at bit 13 and not at some other bit.

**Status register.** It gets staggered set pulses, then writes of masks that mix ones and zeros, then a clearing write that lands in the same cycle as a set pulse. These patterns separate sticky OR behaviour, clear-by-zero, and set priority from plain register loading.

**Unmapped addresses.** Group-1 aliases and numbers lying between mapped registers are written with all ones. Neighbouring registers are then read back to catch decode that is too wide.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int XLEN  = 32;
  localparam int GRP_W = 5;
  localparam int NUM_W = 11;
  localparam int EVBA_LSB = 13;
  localparam int ISR_N = 8;

  localparam logic [NUM_W-1:0] NUM_VER  = 11'd0;
  localparam logic [NUM_W-1:0] NUM_CFG  = 11'd2;
  localparam logic [NUM_W-1:0] NUM_VER2 = 11'd9;
  localparam logic [NUM_W-1:0] NUM_AVER = 11'd10;
  localparam logic [NUM_W-1:0] NUM_EVBA = 11'd11;
  localparam logic [NUM_W-1:0] NUM_AEC  = 11'd12;
  localparam logic [NUM_W-1:0] NUM_AES  = 11'd13;
  localparam logic [NUM_W-1:0] NUM_ISR0 = 11'd21;

  // configuration word presence bit positions
  localparam int CFG_ND   = 10;
  localparam int CFG_AVP  = 11;
  localparam int CFG_EVP  = 12;
  localparam int CFG_ISP  = 13;
  localparam int CFG_AEP  = 14;
  localparam int VER_V2P  = 6;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic [NUM_W-1:0] num;
  } spr_addr_t;
endpackage

// File: rtl/sysreg_id_bank.sv
module sysreg_id_bank
  import sysreg_pkg::*;
#(
  parameter logic [XLEN-1:0]       VER_BASE  = 32'h0,
  parameter logic [XLEN-1:0]       CFG_BASE  = 32'h0,
  parameter logic [7:0]            CPU_ID    = 8'h0,
  parameter logic [23:0]           IMPL_VER  = 24'h0,
  parameter logic [XLEN-1:0]       ARCH_VER  = 32'h0,
  parameter bit                    NO_DSLOT  = 1'b0,
  parameter bit                    HAS_EVBA  = 1'b1,
  parameter bit                    HAS_AE    = 1'b1,
  parameter bit                    HAS_ISR   = 1'b1,
  parameter logic [ISR_N*XLEN-1:0] ISR_INIT  = '0
) (
  input  logic             grp0_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [XLEN-1:0]  rdata_o
);
  localparam logic [XLEN-1:0] PRES_MASK = XLEN'(32'h1F) << CFG_ND;
  localparam logic [XLEN-1:0] PRES_BITS =
      (XLEN'(NO_DSLOT) << CFG_ND) | (XLEN'(1) << CFG_AVP) |
      (XLEN'(HAS_EVBA) << CFG_EVP) | (XLEN'(HAS_ISR) << CFG_ISP) |
      (XLEN'(HAS_AE) << CFG_AEP);
  localparam logic [XLEN-1:0] VER_WORD = VER_BASE | (XLEN'(1) << VER_V2P);
  localparam logic [XLEN-1:0] CFG_WORD = (CFG_BASE & ~PRES_MASK) | PRES_BITS;
  localparam logic [XLEN-1:0] VER2_WORD = {CPU_ID, IMPL_VER};

  logic [XLEN-1:0] isr_rd;

  generate
    if (HAS_ISR) begin : g_isr
      always_comb begin
        isr_rd = '0;
        for (int k = 0; k < ISR_N; k++)
          if (num_i == NUM_W'(int'(NUM_ISR0) + k)) isr_rd = ISR_INIT[k*XLEN +: XLEN];
      end
    end else begin : g_no_isr
      assign isr_rd = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (grp0_i) begin
      unique case (num_i)
        NUM_VER:  rdata_o = VER_WORD;
        NUM_CFG:  rdata_o = CFG_WORD;
        NUM_VER2: rdata_o = VER2_WORD;
        NUM_AVER: rdata_o = ARCH_VER;
        default:  rdata_o = isr_rd;
      endcase
    end
  end
endmodule

// File: rtl/sysreg_evbar.sv
module sysreg_evbar
  import sysreg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [XLEN-1:EVBA_LSB]   wdata_i,
  output logic [XLEN-1:0]          evbar_o
);
  logic [XLEN-1:EVBA_LSB] base_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   base_q <= '0;
    else if (we_i) base_q <= wdata_i;

  assign evbar_o = {base_q, {EVBA_LSB{1'b0}}};

  assert_evba_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> evbar_o[XLEN-1:EVBA_LSB] == $past(wdata_i));
  assert_evba_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(evbar_o));
endmodule

// File: rtl/sysreg_arith_exc.sv
module sysreg_arith_exc
  import sysreg_pkg::*;
#(
  parameter int AE_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_ctl_i,
  input  logic            we_sts_i,
  input  logic [AE_W-1:0] wdata_i,
  input  logic [AE_W-1:0] set_i,
  output logic [AE_W-1:0] ctl_o,
  output logic [AE_W-1:0] sts_o
);
  logic [AE_W-1:0] ctl_q, sts_q, sts_d;

  // set wins over a software clear in the same cycle
  assign sts_d = set_i | (we_sts_i ? (sts_q & wdata_i) : sts_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      if (we_ctl_i) ctl_q <= wdata_i;
      sts_q <= sts_d;
    end

  assign ctl_o = ctl_q;
  assign sts_o = sts_q;

  assert_sts_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (sts_o & $past(set_i)) == $past(set_i));
  assert_sts_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_sts_i |=> ($past(sts_o) & ~sts_o) == '0);
  assert_sts_noset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_sts_i |=> (sts_o & ~$past(sts_o) & ~$past(set_i)) == '0);
  assert_ctl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ctl_i |=> $stable(ctl_o));
endmodule

// File: rtl/sysreg_grp0.sv
module sysreg_grp0
  import sysreg_pkg::*;
#(
  parameter logic [XLEN-1:0]       VER_BASE = 32'h1200_0001,
  parameter logic [XLEN-1:0]       CFG_BASE = 32'h0000_0020,
  parameter logic [7:0]            CPU_ID   = 8'h5A,
  parameter logic [23:0]           IMPL_VER = 24'h00_0102,
  parameter logic [XLEN-1:0]       ARCH_VER = 32'h0100_0000,
  parameter bit                    NO_DSLOT = 1'b1,
  parameter bit                    HAS_EVBA = 1'b1,
  parameter bit                    HAS_AE   = 1'b1,
  parameter bit                    HAS_ISR  = 1'b1,
  parameter int                    AE_W     = 8,
  parameter logic [ISR_N*XLEN-1:0] ISR_INIT =
    256'hC0DE0077_C0DE0066_C0DE0055_C0DE0044_C0DE0033_C0DE0022_C0DE0011_C0DE0000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [GRP_W+NUM_W-1:0] spr_addr_i,
  input  logic                   spr_we_i,
  input  logic [XLEN-1:0]        spr_wdata_i,
  input  logic [AE_W-1:0]        aes_set_i,
  output logic [XLEN-1:0]        spr_rdata_o,
  output logic [XLEN-1:0]        evbar_o,
  output logic [AE_W-1:0]        aecr_o,
  output logic [AE_W-1:0]        aesr_o
);
  spr_addr_t       addr;
  logic            grp0;
  logic [XLEN-1:0] id_rd, evba_rd, ae_rd;

  assign addr = spr_addr_i;
  assign grp0 = (addr.grp == '0);

  sysreg_id_bank #(
    .VER_BASE(VER_BASE), .CFG_BASE(CFG_BASE), .CPU_ID(CPU_ID), .IMPL_VER(IMPL_VER),
    .ARCH_VER(ARCH_VER), .NO_DSLOT(NO_DSLOT), .HAS_EVBA(HAS_EVBA), .HAS_AE(HAS_AE),
    .HAS_ISR(HAS_ISR), .ISR_INIT(ISR_INIT)
  ) u_id (
    .grp0_i (grp0),
    .num_i  (addr.num),
    .rdata_o(id_rd)
  );

  generate
    if (HAS_EVBA) begin : g_evba
      logic sel;
      assign sel = grp0 && (addr.num == NUM_EVBA);
      sysreg_evbar u_evbar (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (spr_we_i && sel),
        .wdata_i(spr_wdata_i[XLEN-1:EVBA_LSB]),
        .evbar_o(evbar_o)
      );
      assign evba_rd = sel ? evbar_o : '0;
    end else begin : g_no_evba
      assign evbar_o = '0;
      assign evba_rd = '0;
    end

    if (HAS_AE) begin : g_ae
      logic sel_c, sel_s;
      assign sel_c = grp0 && (addr.num == NUM_AEC);
      assign sel_s = grp0 && (addr.num == NUM_AES);
      sysreg_arith_exc #(.AE_W(AE_W)) u_ae (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_ctl_i(spr_we_i && sel_c),
        .we_sts_i(spr_we_i && sel_s),
        .wdata_i (spr_wdata_i[AE_W-1:0]),
        .set_i   (aes_set_i),
        .ctl_o   (aecr_o),
        .sts_o   (aesr_o)
      );
      assign ae_rd = sel_c ? XLEN'(aecr_o) : (sel_s ? XLEN'(aesr_o) : '0);
    end else begin : g_no_ae
      assign aecr_o = '0;
      assign aesr_o = '0;
      assign ae_rd  = '0;
    end
  endgenerate

  assign spr_rdata_o = id_rd | evba_rd | ae_rd;

  assert_other_grp_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp0 |-> spr_rdata_o == '0);
  assert_ver_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp0 && addr.num == NUM_VER) |-> spr_rdata_o[VER_V2P]);
  assert_evba_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp0 && addr.num == NUM_EVBA) |-> spr_rdata_o[EVBA_LSB-1:0] == '0);
endmodule

// File: tb/sysreg_grp0_tb.sv
module sysreg_grp0_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  aset = '0;
  logic [31:0] rd_full, rd_min, evb_full, evb_min;
  logic [7:0]  aec_full, aes_full, aec_min, aes_min;

  logic        chk_v = 1'b0;
  logic [31:0] exp_q[$];
  bit          sel_q[$];
  string       tag_q[$];
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sysreg_grp0 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .spr_addr_i(addr), .spr_we_i(we), .spr_wdata_i(wdata),
    .aes_set_i(aset), .spr_rdata_o(rd_full), .evbar_o(evb_full), .aecr_o(aec_full),
    .aesr_o(aes_full));

  sysreg_grp0 #(.NO_DSLOT(1'b0), .HAS_EVBA(1'b0), .HAS_AE(1'b0), .HAS_ISR(1'b0)) u_min (
    .clk_i(clk), .rst_ni(rst_n), .spr_addr_i(addr), .spr_we_i(we), .spr_wdata_i(wdata),
    .aes_set_i(aset), .spr_rdata_o(rd_min), .evbar_o(evb_min), .aecr_o(aec_min),
    .aesr_o(aes_min));

  function automatic logic [15:0] ad(input int g, input int n);
    return {g[4:0], n[10:0]};
  endfunction

  task automatic rd(input bit sel, input logic [15:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = a; we = 1'b0; aset = '0; chk_v = 1'b1;
    exp_q.push_back(e); sel_q.push_back(sel); tag_q.push_back(t);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [7:0] s);
    @(posedge clk); #1;
    addr = a; we = 1'b1; wdata = d; aset = s; chk_v = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] s);
    @(posedge clk); #1;
    we = 1'b0; aset = s; chk_v = 1'b0;
  endtask

  // monitor: compares combinational read data mid-cycle
  always @(negedge clk) begin
    if (chk_v && exp_q.size() > 0) begin
      logic [31:0] e, got;
      bit s;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      got = s ? rd_min : rd_full;
      n_chk++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: got %08h expected %08h", t, got, e);
      end
    end
  end

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(0, ad(0, 11), 32'h0, "R6 evbar reset");
    rd(0, ad(0, 12), 32'h0, "R7 aecr reset");
    rd(0, ad(0, 13), 32'h0, "R8 aesr reset");

    // identification words
    rd(0, ad(0, 0),  32'h1200_0041, "R2 version word full");
    rd(1, ad(0, 0),  32'h1200_0041, "R2 version word min");
    rd(0, ad(0, 2),  32'h0000_7C20, "R3 config full");
    rd(1, ad(0, 2),  32'h0000_0820, "R3 config min R12");
    rd(0, ad(0, 9),  32'h5A00_0102, "R4 R1 version2");
    rd(0, ad(0, 10), 32'h0100_0000, "R4 arch version");
    for (int k = 0; k < 8; k++)
      rd(0, ad(0, 21 + k), 32'hC0DE_0000 + 32'(k) * 32'h11, "R10 impl word");
    rd(1, ad(0, 21), 32'h0, "R12 impl word absent");

    // read-only words ignore writes
    wr(ad(0, 0), 32'hFFFF_FFFF, 8'h0);
    wr(ad(0, 2), 32'h0, 8'h0);
    wr(ad(0, 9), 32'h0, 8'h0);
    wr(ad(0, 22), 32'h0, 8'h0);
    rd(0, ad(0, 0),  32'h1200_0041, "R5 version after write");
    rd(0, ad(0, 2),  32'h0000_7C20, "R5 config after write");
    rd(0, ad(0, 9),  32'h5A00_0102, "R5 version2 after write");
    rd(0, ad(0, 22), 32'hC0DE_0011, "R5 impl word after write");

    // vector base
    wr(ad(0, 11), 32'hFFFF_FFFF, 8'h0);
    rd(0, ad(0, 11), 32'hFFFF_E000, "R6 evbar ones");
    wr(ad(0, 11), 32'h1234_5678, 8'h0);
    rd(0, ad(0, 11), 32'h1234_4000, "R6 evbar pattern");
    rd(1, ad(0, 11), 32'h0, "R12 evbar absent");

    // arithmetic control
    wr(ad(0, 12), 32'hFFFF_FFFF, 8'h0);
    rd(0, ad(0, 12), 32'h0000_00FF, "R7 aecr mask");
    rd(1, ad(0, 12), 32'h0, "R12 aecr absent");

    // status sticky set
    pulse(8'h05);
    rd(0, ad(0, 13), 32'h05, "R8 set pulse");
    pulse(8'h30);
    pulse(8'h00);
    rd(0, ad(0, 13), 32'h35, "R8 sticky accumulate");
    wr(ad(0, 13), 32'h0000_00F0, 8'h0);
    rd(0, ad(0, 13), 32'h30, "R9 clear by zero");
    wr(ad(0, 13), 32'h0000_00FF, 8'h0);
    rd(0, ad(0, 13), 32'h30, "R9 one does not set");
    wr(ad(0, 13), 32'h0, 8'h02);
    rd(0, ad(0, 13), 32'h02, "R9 set wins over clear");
    rd(1, ad(0, 13), 32'h0, "R12 aesr absent");

    // unmapped space
    wr(ad(1, 11), 32'hFFFF_FFFF, 8'h0);
    rd(0, ad(1, 11), 32'h0, "R11 other group read");
    rd(0, ad(1, 0),  32'h0, "R11 R1 group alias of version");
    rd(0, ad(0, 11), 32'h1234_4000, "R11 evbar untouched");
    wr(ad(0, 14), 32'hFFFF_FFFF, 8'h0);
    wr(ad(0, 20), 32'h0, 8'h0);
    rd(0, ad(0, 14), 32'h0, "R11 gap 14");
    rd(0, ad(0, 3),  32'h0, "R11 gap 3");
    rd(0, ad(0, 29), 32'h0, "R11 gap 29");
    rd(0, ad(0, 12), 32'h0000_00FF, "R11 aecr untouched");
    rd(0, ad(0, 13), 32'h02, "R11 aesr untouched");

    @(posedge clk); #1 chk_v = 1'b0;
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule